// File: doc/BRIEF.md
# Raster Timing Generator for Parallel RGB Panels

This block derives the line and frame timing of a parallel RGB TFT panel from a set of programmed words. Two counters walk the raster, one in pixels along a line and one in lines down a frame, and both are exposed so a downstream pixel pipeline knows which pixel to present. From the counters the block decodes horizontal sync, vertical sync and data-enable, each with a selectable polarity. It also qualifies the pixel tick and reports which pixel-clock edge the panel interface should launch data on.

All positions are absolute counts measured from the start of sync. The active window on each axis is a start/end pair: the back porch is whatever lies between the sync width and the start, and the front porch is whatever lies between the end and the total. The configuration is copied into shadow registers at each frame start, so software may rewrite it while the panel runs. Stopping is graceful: a stop request is honoured only on the final pixel of the final line, after which the block sits idle with counters at zero and raises a status flag. That flag must be cleared before the block will start again.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset both counters read 0, the stopped flag `stat_idle` is 0, the generator is idle and hsync, vsync and data-enable sit at their inactive level.
- R2: While running, `h_cnt` counts 0 to htotal-1 and advances only in cycles with `pix_tick` high; `v_cnt` advances when `h_cnt` wraps and counts 0 to vtotal-1. `total_word` holds htotal in bits [31:16] and vtotal in bits [15:0].
- R3: Horizontal sync is active while `h_cnt` is below `hsync_w`, vertical sync while `v_cnt` is below `vsync_w`; both width inputs are 10 bits.
- R4: Data-enable is active only when `h_cnt` lies in [hstart, hend) and `v_cnt` lies in [vstart, vend); `hact_word` and `vact_word` each carry the start in bits [31:16] and the end in bits [15:0].
- R5: `cfg_word` bit 11 makes hsync active-low, bit 9 makes data-enable active-low, bit 8 makes vsync active-low; the inactive level is the complement of the active level.
- R6: `lcd_fall_edge` reflects `cfg_word` bit 10 (launch on falling pixel-clock edge); `pix_qual` is high exactly when the generator runs and `pix_tick` is high.
- R7: When idle with `stat_idle` at 0, `ctrl_word` bit 3 set and bit 4 clear, the generator starts on the next clock edge with both counters at 0.
- R8: With `ctrl_word` bit 4 set, the generator stops only at the edge that consumes the last pixel of the last line; it then holds both counters at 0, drives inactive outputs and sets `stat_idle`.
- R9: While `stat_idle` is 1 the generator stays idle whatever `ctrl_word` holds; a `stat_clr` pulse clears the flag, and a start may follow on the next edge.
- R10: Changes to the configuration inputs made while running take effect at the next frame start, not within the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_tick | input | 1 | One-cycle pixel advance qualifier |
| cfg_word | input | 32 | Polarity and launch-edge controls |
| hsync_w | input | SW (10) | Horizontal sync width in pixels |
| vsync_w | input | SW (10) | Vertical sync width in lines |
| total_word | input | 32 | Horizontal and vertical totals |
| hact_word | input | 32 | Horizontal active start and end |
| vact_word | input | 32 | Vertical active start and end |
| ctrl_word | input | 32 | Bit 3 enable, bit 4 stop request |
| stat_clr | input | 1 | Pulse clearing the stopped flag |
| lcd_hsync | output | 1 | Horizontal sync |
| lcd_vsync | output | 1 | Vertical sync |
| lcd_de | output | 1 | Data-enable |
| lcd_fall_edge | output | 1 | Launch data on falling pixel-clock edge |
| pix_qual | output | 1 | Qualified pixel tick |
| h_cnt | output | CW (16) | Pixel position in line |
| v_cnt | output | CW (16) | Line position in frame |
| stat_idle | output | 1 | Stopped flag |

## Verification
The frame-end edge carries two functions at once: the wrap that reloads the shadow configuration and begins a new frame, and the honouring of a pending stop request. The bench raises the stop bit part way through a frame and again holds it across a whole frame, then judges the edge after the last pixel of the last line: counters must be zero, the flag set and no new frame begun, while one pixel earlier the flag must still be clear. A second coincidence, a flag clear arriving while the enable bit is held, is checked for the one-edge gap before restart.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } lcdt_state_e;

   // bit positions inside the configuration and control words
   localparam int unsigned BIT_INV_HS  = 11;
   localparam int unsigned BIT_FALL    = 10;
   localparam int unsigned BIT_INV_DE  = 9;
   localparam int unsigned BIT_INV_VS  = 8;
   localparam int unsigned BIT_RUN_EN  = 3;
   localparam int unsigned BIT_STOP_RQ = 4;
   localparam int unsigned HI_LSB      = 16;
endpackage

// File: rtl/lcdt_axis_ctr.sv
module lcdt_axis_ctr #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] last_val,
   output logic [W-1:0] cnt,
   output logic         at_last
);
   generate
      if (W < 2) begin : g_bad_w
         $error("lcdt_axis_ctr: W must be at least 2");
      end
   endgenerate

   assign at_last = (cnt == last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clr)     cnt <= '0;
      else if (step)    cnt <= at_last ? '0 : cnt + 1'b1;
   end

   AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr) |=> $stable(cnt)); // R2
endmodule

// File: rtl/lcdt_window.sv
module lcdt_window #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] pos,
   input  logic [W-1:0] sync_w,
   input  logic [W-1:0] beg,
   input  logic [W-1:0] fin,
   output logic         in_sync,
   output logic         in_act
);
   always_comb begin
      in_sync = (pos < sync_w);
      in_act  = (pos >= beg) && (pos < fin);
   end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
   import lcdt_pkg::*;
#(
   parameter int unsigned CW = 16,
   parameter int unsigned SW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pix_tick,
   input  logic [31:0]   cfg_word,
   input  logic [SW-1:0] hsync_w,
   input  logic [SW-1:0] vsync_w,
   input  logic [31:0]   total_word,
   input  logic [31:0]   hact_word,
   input  logic [31:0]   vact_word,
   input  logic [31:0]   ctrl_word,
   input  logic          stat_clr,
   output logic          lcd_hsync,
   output logic          lcd_vsync,
   output logic          lcd_de,
   output logic          lcd_fall_edge,
   output logic          pix_qual,
   output logic [CW-1:0] h_cnt,
   output logic [CW-1:0] v_cnt,
   output logic          stat_idle
);
   localparam int unsigned NAX = 2;

   generate
      if (CW > 16 || CW < 2) begin : g_bad_cw
         $error("lcd_timing_gen: CW must lie in 2..16");
      end
      if (SW > CW) begin : g_bad_sw
         $error("lcd_timing_gen: SW may not exceed CW");
      end
   endgenerate

   lcdt_state_e state_q;
   logic        stat_q;

   // shadow copy of the configuration, refreshed at frame start
   logic [CW-1:0] sh_tot [NAX];
   logic [CW-1:0] sh_sw  [NAX];
   logic [CW-1:0] sh_beg [NAX];
   logic [CW-1:0] sh_fin [NAX];
   logic          sh_inv_hs, sh_inv_vs, sh_inv_de, sh_fall;

   logic [CW-1:0] cnt     [NAX];
   logic [CW-1:0] lim     [NAX];
   logic [NAX-1:0] at_last, step, in_sync, in_act;

   logic running, frame_end, stop_now, start_now, shadow_ld, ctr_clr;

   assign running   = (state_q == ST_RUN);
   assign frame_end = running && pix_tick && at_last[0] && at_last[1];
   assign stop_now  = frame_end && ctrl_word[BIT_STOP_RQ];
   assign start_now = !running && !stat_q && ctrl_word[BIT_RUN_EN]
                      && !ctrl_word[BIT_STOP_RQ];
   assign shadow_ld = !running || frame_end;
   assign ctr_clr   = !running || stop_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         stat_q  <= 1'b0;
      end else begin
         if (running) begin
            if (stop_now) begin
               state_q <= ST_IDLE;
               stat_q  <= 1'b1;
            end
         end else if (stat_q) begin
            if (stat_clr) stat_q <= 1'b0;
         end else if (start_now) begin
            state_q <= ST_RUN;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < NAX; a++) begin
            sh_tot[a] <= '0;
            sh_sw[a]  <= '0;
            sh_beg[a] <= '0;
            sh_fin[a] <= '0;
         end
         sh_inv_hs <= 1'b0;
         sh_inv_vs <= 1'b0;
         sh_inv_de <= 1'b0;
         sh_fall   <= 1'b0;
      end else if (shadow_ld) begin
         sh_tot[0] <= total_word[HI_LSB +: CW];
         sh_tot[1] <= total_word[CW-1:0];
         sh_sw[0]  <= CW'(hsync_w);
         sh_sw[1]  <= CW'(vsync_w);
         sh_beg[0] <= hact_word[HI_LSB +: CW];
         sh_fin[0] <= hact_word[CW-1:0];
         sh_beg[1] <= vact_word[HI_LSB +: CW];
         sh_fin[1] <= vact_word[CW-1:0];
         sh_inv_hs <= cfg_word[BIT_INV_HS];
         sh_inv_vs <= cfg_word[BIT_INV_VS];
         sh_inv_de <= cfg_word[BIT_INV_DE];
         sh_fall   <= cfg_word[BIT_FALL];
      end
   end

   assign step[0] = running && pix_tick;
   assign step[1] = step[0] && at_last[0];

   generate
      for (genvar a = 0; a < NAX; a++) begin : g_axis
         assign lim[a] = sh_tot[a] - 1'b1;

         lcdt_axis_ctr #(.W(CW)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (ctr_clr),
            .step     (step[a]),
            .last_val (lim[a]),
            .cnt      (cnt[a]),
            .at_last  (at_last[a])
         );

         lcdt_window #(.W(CW)) u_win (
            .pos     (cnt[a]),
            .sync_w  (sh_sw[a]),
            .beg     (sh_beg[a]),
            .fin     (sh_fin[a]),
            .in_sync (in_sync[a]),
            .in_act  (in_act[a])
         );
      end
   endgenerate

   assign h_cnt         = cnt[0];
   assign v_cnt         = cnt[1];
   assign lcd_hsync     = (running && in_sync[0]) ^ sh_inv_hs;
   assign lcd_vsync     = (running && in_sync[1]) ^ sh_inv_vs;
   assign lcd_de        = (running && in_act[0] && in_act[1]) ^ sh_inv_de;
   assign lcd_fall_edge = sh_fall;
   assign pix_qual      = running && pix_tick;
   assign stat_idle     = stat_q;

   logic unused_bits;
   assign unused_bits = ^{cfg_word, ctrl_word, total_word, hact_word, vact_word};

   AST_STAT_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q) |-> $past(frame_end && ctrl_word[BIT_STOP_RQ])); // R8
   AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (h_cnt == '0 && v_cnt == '0)); // R8
   AST_STOPPED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q && !running) |=> !running); // R9
   AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !frame_end) |=> ($stable(sh_sw[0]) && $stable(sh_tot[0]))); // R10
   AST_VSTEP_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !(pix_tick && at_last[0])) |=> $stable(v_cnt)); // R2
endmodule

// File: tb/lcd_timing_gen_bench.sv
module lcd_timing_gen_bench;
   typedef struct packed {
      logic [15:0] ht, vt, hsw, vsw, hs, he, vs, ve;
      logic [3:0]  cf; // {inv_hs, fall, inv_de, inv_vs}
   } vec_t;

   localparam int NV = 3;
   localparam vec_t VECS [NV] = '{
      '{16'd12, 16'd6, 16'd2, 16'd1, 16'd4, 16'd10, 16'd2, 16'd5, 4'b0000},
      '{16'd10, 16'd5, 16'd3, 16'd2, 16'd4, 16'd9,  16'd2, 16'd4, 4'b1111},
      '{16'd8,  16'd4, 16'd1, 16'd1, 16'd2, 16'd8,  16'd1, 16'd4, 4'b1000}
   };

   logic clk = 1'b0, rst_n = 1'b0, pix_tick = 1'b0, stat_clr = 1'b0;
   logic [31:0] cfg_word = '0, total_word = '0, hact_word = '0, vact_word = '0, ctrl_word = '0;
   logic [9:0]  hsync_w = '0, vsync_w = '0;
   logic lcd_hsync, lcd_vsync, lcd_de, lcd_fall_edge, pix_qual, stat_idle;
   logic [15:0] h_cnt, v_cnt;

   always #5 clk = ~clk;

   lcd_timing_gen u_lcd_timing_gen (
      .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .cfg_word(cfg_word),
      .hsync_w(hsync_w), .vsync_w(vsync_w), .total_word(total_word),
      .hact_word(hact_word), .vact_word(vact_word), .ctrl_word(ctrl_word),
      .stat_clr(stat_clr), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
      .lcd_de(lcd_de), .lcd_fall_edge(lcd_fall_edge), .pix_qual(pix_qual),
      .h_cnt(h_cnt), .v_cnt(v_cnt), .stat_idle(stat_idle));

   int errors = 0, checks = 0;
   bit finished = 1'b0;
   vec_t lv, es;
   bit erun, estat;
   int eh, ev;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (h=%0d v=%0d)", tag, act, exp, eh, ev);
      end
   endtask

   task automatic drive_live(input vec_t v);
      lv         = v;
      total_word = {v.ht, v.vt};
      hact_word  = {v.hs, v.he};
      vact_word  = {v.vs, v.ve};
      hsync_w    = v.hsw[9:0];
      vsync_w    = v.vsw[9:0];
      cfg_word   = {20'd0, v.cf, 8'd0};
   endtask

   // expected output levels from the model state
   task automatic cmp();
      bit xh, xv, xd;
      xh = (erun && eh < int'(es.hsw)) ^ es.cf[3];
      xv = (erun && ev < int'(es.vsw)) ^ es.cf[0];
      xd = (erun && eh >= int'(es.hs) && eh < int'(es.he)
                 && ev >= int'(es.vs) && ev < int'(es.ve)) ^ es.cf[1];
      chk(int'(h_cnt) == eh, "R2 h_cnt", int'(h_cnt), eh);
      chk(int'(v_cnt) == ev, "R2 v_cnt", int'(v_cnt), ev);
      chk(lcd_hsync == xh, "R3/R5 hsync", int'(lcd_hsync), int'(xh));
      chk(lcd_vsync == xv, "R3/R5 vsync", int'(lcd_vsync), int'(xv));
      chk(lcd_de == xd, "R4/R5 de", int'(lcd_de), int'(xd));
      chk(lcd_fall_edge == es.cf[2], "R6 fall_edge", int'(lcd_fall_edge), int'(es.cf[2]));
      chk(pix_qual == (erun && pix_tick), "R6 pix_qual", int'(pix_qual), int'(erun && pix_tick));
      chk(stat_idle == estat, "R8/R9 stat_idle", int'(stat_idle), int'(estat));
   endtask

   // one clock: inputs set now (negedge), model follows the edge, compare at next negedge
   task automatic cyc(input bit tk);
      bit en, stp, clr;
      pix_tick = tk;
      en  = ctrl_word[3];
      stp = ctrl_word[4];
      clr = stat_clr;
      @(posedge clk);
      if (!erun) begin
         es = lv; eh = 0; ev = 0;
         if (estat) begin
            if (clr) estat = 0;
         end else if (en && !stp) erun = 1;
      end else if (tk) begin
         if (eh == int'(es.ht) - 1 && ev == int'(es.vt) - 1) begin
            es = lv; eh = 0; ev = 0;
            if (stp) begin erun = 0; estat = 1; end
         end else if (eh == int'(es.ht) - 1) begin
            eh = 0; ev++;
         end else eh++;
      end
      @(negedge clk);
      cmp();
   endtask

   task automatic do_reset();
      rst_n = 1'b0; ctrl_word = '0; stat_clr = 1'b0; pix_tick = 1'b0;
      erun = 0; estat = 0; eh = 0; ev = 0; es = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      // R1: reset state, before any live config reaches the shadow
      do_reset();
      cmp();
      chk(h_cnt == 0 && v_cnt == 0, "R1 counters", int'(h_cnt), 0);
      chk(stat_idle == 1'b0, "R1 stat", int'(stat_idle), 0);
      chk({lcd_hsync, lcd_vsync, lcd_de} == 3'b000, "R1 outputs", int'({lcd_hsync, lcd_vsync, lcd_de}), 0);

      // table walk: one configuration per vector, full frames, then a graceful stop
      for (int k = 0; k < NV; k++) begin
         do_reset();
         drive_live(VECS[k]);
         cyc(1'b0);                         // idle: shadow picks up config
         ctrl_word = 32'h8;                 // R7 start
         cyc(1'b1);
         chk(pix_qual == 1'b1 && h_cnt == 0 && v_cnt == 0, "R7 start at zero", int'(h_cnt), 0);
         for (int n = 0; n < int'(VECS[k].ht) * int'(VECS[k].vt) + 4; n++) cyc(1'b1);
         ctrl_word = 32'h18;                // R8 stop request mid-frame
         for (int n = 0; n < 200 && !estat; n++) begin
            if (erun) chk(stat_idle == 1'b0, "R8 no early stop", int'(stat_idle), 0);
            cyc(1'b1);
         end
         chk(stat_idle == 1'b1 && h_cnt == 0 && v_cnt == 0, "R8 stopped at frame end",
             int'(stat_idle), 1);
         chk({lcd_hsync, lcd_vsync, lcd_de} == {VECS[k].cf[3], VECS[k].cf[0], VECS[k].cf[1]},
             "R8 inactive levels", int'({lcd_hsync, lcd_vsync, lcd_de}),
             int'({VECS[k].cf[3], VECS[k].cf[0], VECS[k].cf[1]}));
      end

      // R9: flag holds the generator idle even with enable set
      ctrl_word = 32'h8;
      repeat (4) cyc(1'b1);
      chk(pix_qual == 1'b0 && stat_idle == 1'b1, "R9 held idle", int'(pix_qual), 0);
      stat_clr = 1'b1;
      cyc(1'b1);
      stat_clr = 1'b0;
      chk(stat_idle == 1'b0 && pix_qual == 1'b0, "R9 cleared, not yet started", int'(pix_qual), 0);
      cyc(1'b1);
      chk(pix_qual == 1'b1 && h_cnt == 0, "R9 restart after clear", int'(pix_qual), 1);

      // R2: counters hold while the tick is low
      do_reset();
      drive_live(VECS[0]);
      cyc(1'b0);
      ctrl_word = 32'h8;
      cyc(1'b1);
      repeat (3) cyc(1'b1);
      repeat (3) cyc(1'b0);
      chk(h_cnt == 3 && pix_qual == 1'b0, "R2 hold without tick", int'(h_cnt), 3);

      // R10: mid-frame write of the hsync width waits for the next frame
      begin
         vec_t nv;
         nv = VECS[0];
         nv.hsw = 16'd5;
         drive_live(nv);
         repeat (2) cyc(1'b1);
         chk(h_cnt == 5 && lcd_hsync == 1'b0, "R10 old width this frame", int'(lcd_hsync), 0);
         for (int n = 0; n < 200 && !(ev == 0 && eh == 3 && n > 5); n++) cyc(1'b1);
         chk(h_cnt == 3 && lcd_hsync == 1'b1, "R10 new width next frame", int'(lcd_hsync), 1);
      end

      // R8 corner: stop bit raised exactly on the last pixel of the last line
      for (int n = 0; n < 200 && !(eh == int'(es.ht) - 1 && ev == int'(es.vt) - 1); n++) cyc(1'b1);
      ctrl_word = 32'h18;
      chk(stat_idle == 1'b0 && pix_qual == 1'b1, "R8 last pixel still running", int'(stat_idle), 0);
      cyc(1'b1);
      chk(stat_idle == 1'b1 && h_cnt == 0 && pix_qual == 1'b0, "R8 stop on same edge", int'(stat_idle), 1);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL R2 watchdog: actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule